// File: doc/BRIEF.md
# Bit-Serial Save-Memory Emulator

This block stands in for a small serial save memory that a processor drives one bit at a time over a 16-bit bus. Each halfword write into the block's address window carries one serial input bit in bit 0. Each halfword read returns one serial output bit in bit 0. A transaction opens with a 2-bit command and a 6-bit block number. A read then ends with a zero stop bit, four dummy reads and 64 returned data bits. A write carries 64 data bits and then a zero stop bit. The data lives in a 512-byte on-chip array organised as 64 blocks of 8 bytes.

The block also decides which bus accesses belong to it. Accesses to the 0x0D region reach the sequencer when the cartridge ROM is 16 MiB or smaller. When the ROM is larger, only the top 256 bytes of that region (0x0DFF_FF00 and above) reach it. Every other access returns the normal ROM data, and writes outside the window do nothing.

The sequencer is built from seven states. CMD_WAIT collects the two command bits: 11 goes to ADDR_IN as a read, 10 goes to ADDR_IN as a write, and any other pattern flags an error and stays in CMD_WAIT. ADDR_IN collects six address bits and goes to RD_STOP for a read or to WR_DATA for a write. RD_STOP goes to DUMMY_OUT on a 0 bit, or back to CMD_WAIT with an error on a 1 bit. DUMMY_OUT goes to RD_DATA after four reads. RD_DATA returns to CMD_WAIT after 64 reads. WR_DATA goes to WR_STOP after 64 bits. WR_STOP returns to CMD_WAIT, and it flags an error if the stop bit is 1. Reset sends any state to CMD_WAIT.

Top module: `serial_save_mem`

## Requirements
- R1: The window is hit when bus_addr[31:24] is 8'h0D and either rom_large is 0 or bus_addr[23:8] is 16'hFFFF. A read outside the window returns rom_rdata unchanged. A write outside the window has no effect on the sequencer or on the array.
- R2: Serial input is bus_wdata bit 0 of a write in the window, and bits 15:1 are ignored. The first two bits received in CMD_WAIT form the command, first bit in the upper position. The pattern 11 selects a read and 10 selects a write.
- R3: The next six bits, most significant first, give a block number B. The transfer covers bytes 8*B through 8*B+7 in ascending order.
- R4: For a read, one stop bit of 0 follows the address. After it, four read accesses return dummy bits. The next 64 reads return the block's data in bit 0, most significant bit of each byte first.
- R5: A read in the window returns 0 in bits 15:1 at all times. It returns 0 in bit 0 whenever the block is not returning data, which includes the four dummy reads.
- R6: ready is 1 exactly during the accesses that return the 64 data bits. After the 64th data bit, the sequencer is back in CMD_WAIT.
- R7: For a write, 64 data bits follow the address, most significant bit of each byte first. All eight bytes are committed to the array, each byte as soon as its eighth bit arrives. A following stop bit of 0 returns the sequencer to CMD_WAIT.
- R8: A command pattern of 00 or 01, a read stop bit of 1, or a write stop bit of 1 sets proto_err and puts the sequencer in CMD_WAIT. proto_err stays at 1 until reset.
- R9: rst is synchronous and active high. It clears proto_err and ready and selects CMD_WAIT, including in the middle of a transaction. The array keeps its contents across reset.
- R10: An access in the wrong direction is ignored. A read does not advance CMD_WAIT, ADDR_IN, RD_STOP, WR_DATA or WR_STOP. A write does not advance DUMMY_OUT or RD_DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the current access |
| bus_wr | input | 1 | One-cycle strobe for a halfword write |
| bus_rd | input | 1 | One-cycle strobe for a halfword read |
| bus_wdata | input | 16 | Write data; only bit 0 is used inside the window |
| rom_large | input | 1 | 1 when the cartridge ROM is larger than 16 MiB |
| rom_rdata | input | 16 | Normal ROM read data, returned outside the window |
| bus_rdata | output | 16 | Read data; combinational during the read strobe |
| ready | output | 1 | High while data bits are being returned |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The read and write paths are exercised with blocks 0 and 63, with two neighbouring blocks, and with random data at random blocks. Each pattern separates a wrong block scaling, a bit-order swap or a byte-order swap from correct behaviour, and neighbouring blocks that keep their own contents show that address decoding is right. Directed sequences cover the cases that distinguish recovery from a hang. These are a bad command, a bad stop bit on a read and on a write, and a reset in the middle of a transaction, each followed by a clean transfer. Window tests under both ROM sizes and accesses in the wrong direction interleaved with data bits separate correct qualification from a sequencer that advances on any strobe.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    typedef enum logic [2:0] {
        CMD_WAIT,
        ADDR_IN,
        RD_STOP,
        DUMMY_OUT,
        RD_DATA,
        WR_DATA,
        WR_STOP
    } ssm_state_e;

    localparam int CMD_BITS = 2;
    localparam logic [1:0] OP_READ  = 2'b11;
    localparam logic [1:0] OP_WRITE = 2'b10;
endpackage

// File: rtl/ssm_window.sv
module ssm_window #(
    parameter logic [7:0]  REGION   = 8'h0D,
    parameter logic [15:0] TAIL_TOP = 16'hFFFF
) (
    input  logic [31:0] addr,
    input  logic        rom_large,
    output logic        hit
);
    logic [7:0] addr_unused;
    assign addr_unused = addr[7:0];

    always_comb begin
        hit = (addr[31:24] == REGION) && (!rom_large || (addr[23:8] == TAIL_TOP));
    end
endmodule

// File: rtl/ssm_store.sv
module ssm_store #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ssm_seq.sv
module ssm_seq
    import ssm_pkg::*;
#(
    parameter int BLK_W      = 6,
    parameter int OFS_W      = 3,
    parameter int DUMMY_BITS = 4,
    parameter int PAYLOAD    = 64,
    localparam int ADDR_W    = BLK_W + OFS_W,
    localparam int CNT_W     = $clog2(PAYLOAD)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              sin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] byte_ptr,
    output logic [2:0]        bit_idx,
    output logic              data_phase,
    output logic              err
);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(PAYLOAD - 1);
    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(BLK_W - 1);
    localparam logic [CNT_W-1:0] LAST_CMD   = CNT_W'(CMD_BITS - 1);

    ssm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BLK_W-1:0]  sh_q, sh_d;
    logic              is_rd_q, is_rd_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [7:0]        byte_q, byte_d;
    logic              err_q, err_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CMD_WAIT;
            cnt_q   <= '0;
            sh_q    <= '0;
            is_rd_q <= 1'b0;
            ptr_q   <= '0;
            byte_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            is_rd_q <= is_rd_d;
            ptr_q   <= ptr_d;
            byte_q  <= byte_d;
            err_q   <= err_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        sh_d      = sh_q;
        is_rd_d   = is_rd_q;
        ptr_d     = ptr_q;
        byte_d    = byte_q;
        err_d     = err_q;
        mem_we    = 1'b0;
        mem_waddr = ptr_q;
        mem_wdata = {byte_q[6:0], sin};
        unique case (state_q)
            CMD_WAIT: begin
                if (wr_stb) begin
                    sh_d  = {sh_q[BLK_W-2:0], sin};
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_CMD) begin
                        cnt_d = '0;
                        sh_d  = '0;
                        if ({sh_q[0], sin} == OP_READ) begin
                            is_rd_d = 1'b1;
                            state_d = ADDR_IN;
                        end else if ({sh_q[0], sin} == OP_WRITE) begin
                            is_rd_d = 1'b0;
                            state_d = ADDR_IN;
                        end else begin
                            err_d = 1'b1;
                        end
                    end
                end
            end
            ADDR_IN: begin
                if (wr_stb) begin
                    sh_d  = {sh_q[BLK_W-2:0], sin};
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_ADDR) begin
                        cnt_d   = '0;
                        ptr_d   = {sh_q[BLK_W-2:0], sin, {OFS_W{1'b0}}};
                        state_d = is_rd_q ? RD_STOP : WR_DATA;
                    end
                end
            end
            RD_STOP: begin
                if (wr_stb) begin
                    cnt_d = '0;
                    if (sin) begin
                        err_d   = 1'b1;
                        state_d = CMD_WAIT;
                    end else begin
                        state_d = DUMMY_OUT;
                    end
                end
            end
            DUMMY_OUT: begin
                if (rd_stb) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_DUMMY) begin
                        cnt_d   = '0;
                        state_d = RD_DATA;
                    end
                end
            end
            RD_DATA: begin
                if (rd_stb) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q[2:0] == 3'd7) ptr_d = ptr_q + 1'b1;
                    if (cnt_q == LAST_DATA) begin
                        cnt_d   = '0;
                        state_d = CMD_WAIT;
                    end
                end
            end
            WR_DATA: begin
                if (wr_stb) begin
                    byte_d = {byte_q[6:0], sin};
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q[2:0] == 3'd7) begin
                        mem_we = 1'b1;
                        ptr_d  = ptr_q + 1'b1;
                    end
                    if (cnt_q == LAST_DATA) begin
                        cnt_d   = '0;
                        state_d = WR_STOP;
                    end
                end
            end
            WR_STOP: begin
                if (wr_stb) begin
                    if (sin) err_d = 1'b1;
                    state_d = CMD_WAIT;
                end
            end
            default: state_d = CMD_WAIT;
        endcase
    end

    assign byte_ptr   = ptr_q;
    assign bit_idx    = cnt_q[2:0];
    assign data_phase = (state_q == RD_DATA);
    assign err        = err_q;
endmodule

// File: rtl/serial_save_mem.sv
module serial_save_mem #(
    parameter int BYTES      = 512,
    parameter int BLK_BYTES  = 8,
    parameter int DUMMY_BITS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    input  logic        rom_large,
    input  logic [15:0] rom_rdata,
    output logic [15:0] bus_rdata,
    output logic        ready,
    output logic        proto_err
);
    localparam int ADDR_W  = $clog2(BYTES);
    localparam int OFS_W   = $clog2(BLK_BYTES);
    localparam int BLK_W   = ADDR_W - OFS_W;
    localparam int PAYLOAD = BLK_BYTES * 8;

    logic              hit;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] byte_ptr;
    logic [7:0]        rd_byte;
    logic [2:0]        bit_idx;
    logic              data_phase;
    logic [14:0]       wdata_hi_unused;

    assign wdata_hi_unused = bus_wdata[15:1];

    ssm_window u_window (
        .addr      (bus_addr),
        .rom_large (rom_large),
        .hit       (hit)
    );

    ssm_seq #(
        .BLK_W      (BLK_W),
        .OFS_W      (OFS_W),
        .DUMMY_BITS (DUMMY_BITS),
        .PAYLOAD    (PAYLOAD)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (bus_wr && hit),
        .rd_stb     (bus_rd && hit),
        .sin        (bus_wdata[0]),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .byte_ptr   (byte_ptr),
        .bit_idx    (bit_idx),
        .data_phase (data_phase),
        .err        (proto_err)
    );

    ssm_store #(
        .DEPTH (BYTES),
        .AW    (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (byte_ptr),
        .rdata (rd_byte)
    );

    always_comb begin
        if (hit) bus_rdata = {15'd0, data_phase & rd_byte[~bit_idx]};
        else     bus_rdata = rom_rdata;
    end

    assign ready = data_phase;
endmodule

// File: rtl/ssm_chk.sv
module ssm_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] bus_addr,
    input logic        bus_rd,
    input logic        rom_large,
    input logic [15:0] rom_rdata,
    input logic [15:0] bus_rdata,
    input logic        ready,
    input logic        proto_err
);
    logic in_win;
    assign in_win = (bus_addr[31:24] == 8'h0D) && (!rom_large || bus_addr[23:8] == 16'hFFFF);

    AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst) in_win |-> bus_rdata[15:1] == 15'd0); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) (in_win && !ready) |-> !bus_rdata[0]); // R5
    AST_ROM_PATH: assert property (@(posedge clk) disable iff (rst) (bus_addr[31:24] != 8'h0D) |-> bus_rdata == rom_rdata); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) proto_err |=> proto_err); // R8
    AST_READY_START: assert property (@(posedge clk) disable iff (rst) $rose(ready) |-> $past(in_win && bus_rd)); // R6
    AST_READY_END: assert property (@(posedge clk) disable iff (rst) ($fell(ready) && !$past(rst)) |-> $past(in_win && bus_rd)); // R6
endmodule

bind serial_save_mem ssm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .rom_large (rom_large),
    .rom_rdata (rom_rdata),
    .bus_rdata (bus_rdata),
    .ready     (ready),
    .proto_err (proto_err)
);

// File: tb/serial_save_mem_test.sv
module serial_save_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0D00_0000;
    localparam logic [31:0] TAIL = 32'h0DFF_FF00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = BASE;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        rom_large = 1'b0;
    logic [15:0] rom_rdata = 16'hBEEF;
    logic [15:0] bus_rdata;
    logic        ready;
    logic        proto_err;

    int total = 0;
    int bad = 0;
    logic [7:0] model [512];
    logic [31:0] win = BASE;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_save_mem uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .rom_large(rom_large), .rom_rdata(rom_rdata),
        .bus_rdata(bus_rdata), .ready(ready), .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // one bus access; q and r are sampled during the strobe, before the edge
    task automatic acc(input bit w, input bit rd, input logic [31:0] a, input bit b,
                       output logic [15:0] q, output logic r);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = w;
        bus_rd    = rd;
        bus_wdata = {15'($urandom), b};
        #1;
        q = bus_rdata;
        r = ready;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wbit(input bit b);
        logic [15:0] q; logic r;
        acc(1'b1, 1'b0, win, b, q, r);
    endtask

    task automatic rbit(output logic [15:0] q, output logic r);
        acc(1'b0, 1'b1, win, 1'b0, q, r);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_hdr(input bit is_rd, input logic [5:0] blk);
        wbit(1'b1);
        wbit(is_rd);
        for (int i = 5; i >= 0; i--) wbit(blk[i]);
    endtask

    // write a block; optionally interleave reads (R10), stop bit selectable
    task automatic do_write(input logic [5:0] blk, input logic [63:0] data, input bit stopb, input bit mix);
        logic [15:0] q; logic r;
        send_hdr(1'b0, blk);
        for (int i = 0; i < 64; i++) begin
            wbit(data[63-i]);
            if (mix && i[2:0] == 3'd3) begin
                rbit(q, r);
                chk("R10", "read during write data", {15'd0, r, q}, 32'd0);
            end
        end
        wbit(stopb);
        for (int k = 0; k < 8; k++) model[{blk, 3'(k)}] = data[63-8*k -: 8];
    endtask

    // read a block and compare against the model; optionally interleave writes (R10)
    task automatic do_read(input logic [5:0] blk, input bit mix, input string tag);
        logic [15:0] q; logic r; logic [7:0] e;
        send_hdr(1'b1, blk);
        wbit(1'b0);
        for (int i = 0; i < 4; i++) begin
            rbit(q, r);
            chk("R5", "dummy bit data", {16'd0, q}, 32'd0);
            chk("R6", "dummy bit ready", {31'd0, r}, 32'd0);
        end
        for (int i = 0; i < 64; i++) begin
            if (mix && i[2:0] == 3'd5) wbit(1'b1);
            e = model[{blk, 3'(i / 8)}];
            rbit(q, r);
            chk("R4", tag, {16'd0, q}, {31'd0, e[7 - (i % 8)]});
            chk("R6", "ready in data phase", {31'd0, r}, 32'd1);
        end
        rbit(q, r);
        chk("R6", "after 64th bit", {15'd0, r, q}, 32'd0);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R6 watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] q; logic r;
        logic [5:0] blks [12];
        void'($urandom(32'd20240611));
        do_reset();

        // R9 reset state
        chk("R9", "ready after reset", {31'd0, ready}, 32'd0);
        chk("R9", "proto_err after reset", {31'd0, proto_err}, 32'd0);
        rbit(q, r);
        chk("R5", "idle read", {16'd0, q}, 32'd0);
        chk("R10", "read in CMD_WAIT then valid cmd still works", {31'd0, proto_err}, 32'd0);

        // R2 R3 R4 R7 directed corners: blocks 0 and 63
        do_write(6'd0, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);
        chk("R7", "no error after good write", {31'd0, proto_err}, 32'd0);
        do_read(6'd0, 1'b0, "R2 R3 block 0 data");
        do_write(6'd63, 64'hF0E1_D2C3_B4A5_9687, 1'b0, 1'b0);
        do_read(6'd63, 1'b0, "R3 block 63 data");

        // R3 neighbouring blocks
        do_write(6'd5, 64'hAAAA_5555_FFFF_0000, 1'b0, 1'b0);
        do_write(6'd6, 64'h1111_2222_3333_4444, 1'b0, 1'b0);
        do_read(6'd5, 1'b0, "R3 block 5 after block 6 write");
        do_read(6'd6, 1'b0, "R3 block 6 data");

        // random blocks and data
        for (int n = 0; n < 12; n++) begin
            blks[n] = 6'($urandom);
            do_write(blks[n], rnd64(), 1'b0, 1'b0);
        end
        for (int n = 0; n < 12; n++) do_read(blks[n], 1'b0, "R4 random block data");

        // R10 wrong-direction accesses interleaved
        do_write(6'd9, rnd64(), 1'b0, 1'b1);
        do_read(6'd9, 1'b1, "R10 read with interleaved writes");

        // R8 bad command 00 then 01
        wbit(1'b0); wbit(1'b0);
        chk("R8", "cmd 00 error", {31'd0, proto_err}, 32'd1);
        do_read(6'd0, 1'b0, "R8 read after bad command");
        chk("R8", "error sticky", {31'd0, proto_err}, 32'd1);

        // R9 reset clears error, array preserved
        do_reset();
        chk("R9", "error cleared", {31'd0, proto_err}, 32'd0);
        do_read(6'd63, 1'b0, "R9 data kept over reset");
        wbit(1'b0); wbit(1'b1);
        chk("R8", "cmd 01 error", {31'd0, proto_err}, 32'd1);
        do_reset();

        // R8 read stop bit 1
        send_hdr(1'b1, 6'd0);
        wbit(1'b1);
        chk("R8", "read stop 1 error", {31'd0, proto_err}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            rbit(q, r);
            chk("R8", "no data after bad stop", {15'd0, r, q}, 32'd0);
        end
        do_reset();

        // R7 R8 write stop bit 1 still commits
        do_write(6'd20, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0);
        chk("R8", "write stop 1 error", {31'd0, proto_err}, 32'd1);
        do_read(6'd20, 1'b0, "R7 bytes committed before bad stop");
        do_reset();

        // R9 reset mid-transaction
        send_hdr(1'b1, 6'd5);
        wbit(1'b0);
        rbit(q, r); rbit(q, r);
        do_reset();
        do_write(6'd21, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0, 1'b0);
        do_read(6'd21, 1'b0, "R9 transfer after mid reset");

        // R1 window: outside region
        acc(1'b0, 1'b1, 32'h0C00_0000, 1'b0, q, r);
        chk("R1", "rom path read", {16'd0, q}, 32'h0000_BEEF);
        win = 32'h0C00_0010;
        send_hdr(1'b0, 6'd21);
        for (int i = 0; i < 65; i++) wbit(1'b1);
        win = BASE;
        do_read(6'd21, 1'b0, "R1 writes outside window ignored");

        // R1 large ROM
        rom_large = 1'b1;
        rom_rdata = 16'h1357;
        acc(1'b0, 1'b1, BASE, 1'b0, q, r);
        chk("R1", "large rom low region is rom", {16'd0, q}, 32'h0000_1357);
        acc(1'b0, 1'b1, TAIL - 32'd2, 1'b0, q, r);
        chk("R1", "large rom below tail is rom", {16'd0, q}, 32'h0000_1357);
        acc(1'b0, 1'b1, TAIL, 1'b0, q, r);
        chk("R1", "large rom tail is block", {16'd0, q}, 32'd0);
        win = TAIL + 32'h80;
        do_write(6'd33, rnd64(), 1'b0, 1'b0);
        do_read(6'd33, 1'b0, "R1 large rom tail transfer");
        win = BASE;
        send_hdr(1'b0, 6'd33);
        for (int i = 0; i < 65; i++) wbit(1'b0);
        win = TAIL;
        do_read(6'd33, 1'b0, "R1 large rom low region writes ignored");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule